// File: doc/BRIEF.md
# Address-Prefixed Serial Control Slave

This block is a three-wire serial slave that lets a host controller load control words into a tuner's loop-control logic and read status back. The host drives a chip-enable, a shift clock and a data line, and the block returns data on an output line with its own output-enable. Every transfer starts with an 8-bit address, shifted in while chip-enable is low. The rising edge of chip-enable commits the decoded mode.

Three addresses select 24-bit write banks: two for the main loop and one for the auxiliary loop. A word is copied into its bank only when chip-enable falls after exactly 24 data bits. A fourth address selects a read mode. In read mode the block returns one bit per shift clock for as long as the host keeps clocking. The first bit is the level of a bidirectional port pin, then counter data, then zeros. Bank 1 also drives four open-drain port outputs and one bidirectional open-drain port.

All serial inputs are brought into the system clock domain through synchronizers, and edges are detected there. The shift clock must therefore stay in each level for several system clock cycles. The counter input is assumed quasi-static and is captured when a read starts.

Top module: `sps_serial_slave`

## Requirements
- R1: Address bits are taken on shift-clock rising edges while chip-enable is low. The order on the wire is the high nibble LSB first, then the low nibble LSB first. Value 0x82 is therefore sent as 0,0,0,1,0,1,0,0. The mode is decoded from the last eight such bits at the chip-enable rising edge, and it returns to idle when chip-enable falls.
- R2: Address 0x82 targets bank 1, 0x92 targets bank 2 and 0xB2 targets bank 3. A write changes only its own bank.
- R3: While chip-enable is high in a write mode, a data bit is taken on each shift-clock rising edge. The first data bit lands in bank bit 0 and the 24th in bank bit 23.
- R4: A bank is updated only at the chip-enable falling edge, and only when exactly 24 data bits were received. Frames of 23 or 25 bits leave every bank unchanged.
- R5: In read mode (address 0xA2), output-enable is high while chip-enable is high. The first bit, presented at the chip-enable rise, is the bidirectional pin level. Each shift-clock falling edge then presents the next bit: the counter input MSB first, followed by zeros for as many clocks as the host sends.
- R6: Output-enable is low whenever read mode is not active. This covers idle time, write frames and unknown addresses.
- R7: Open-drain port output i (i = 0..3) drives low exactly when bank 1 bit i is 1.
- R8: Bank 1 bit 4 is the bidirectional port direction (1 = output) and bit 5 is its value. The pin is driven low only when both bits are 1.
- R9: After reset all banks are zero, every port floats, the bidirectional port is an input and output-enable is low.
- R10: A frame with an address that matches no mode changes no bank and does not enable the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_en | input | 1 | Serial chip-enable from host |
| ser_clk | input | 1 | Serial shift clock from host |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial data to host |
| ser_dout_oe | output | 1 | Output-enable for ser_dout (low = high impedance) |
| cnt_in | input | CNT_W (20) | Counter data returned in read mode |
| bio_in | input | 1 | Level seen on the bidirectional port pin |
| port_low | output | PORT_N (4) | Open-drain port pull-down enables |
| bio_low | output | 1 | Bidirectional port pull-down enable |
| bank1_q | output | DATA_W (24) | Bank 1 contents |
| bank2_q | output | DATA_W (24) | Bank 2 contents |
| bank3_q | output | DATA_W (24) | Bank 3 contents |

## Verification
The assertions check on every cycle that banks change only in the cycle after a chip-enable release and that no more than one bank updates at a time. They also check that output-enable is raised only in read mode, that the data output holds between falling shift-clock edges, and that the mode is idle while chip-enable stays low. Only the bench scenarios can show the rest. This covers the address bit order, where each data bit lands in a bank, the discarding of 23- and 25-bit frames, unknown addresses, the port outputs, and the full sequence of read bits including the zero tail.

// File: rtl/sps_pkg.sv
// Shared types and address constants for the serial control slave.
// Assumes an 8-bit address whose value is formed high-nibble first.
package sps_pkg;
    typedef enum logic [2:0] {
        MD_IDLE = 3'd0,
        MD_WR1  = 3'd1,
        MD_WR2  = 3'd2,
        MD_WR3  = 3'd3,
        MD_RD   = 3'd4
    } mode_e;

    localparam int unsigned ADDR_W = 8;
    localparam logic [ADDR_W-1:0] ADDR_WR1 = 8'h82;
    localparam logic [ADDR_W-1:0] ADDR_WR2 = 8'h92;
    localparam logic [ADDR_W-1:0] ADDR_WR3 = 8'hB2;
    localparam logic [ADDR_W-1:0] ADDR_RD  = 8'hA2;

    // Map an address value to its transfer mode
    function automatic mode_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            ADDR_WR1: return MD_WR1;
            ADDR_WR2: return MD_WR2;
            ADDR_WR3: return MD_WR3;
            ADDR_RD:  return MD_RD;
            default:  return MD_IDLE;
        endcase
    endfunction
endpackage

// File: rtl/sps_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes STAGES >= 2; every bit sees the same delay.
module sps_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int unsigned CW = W * STAGES;

    logic [CW-1:0] chain;

    // Shift the inputs through the register chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CW-W-1:0], d};
    end

    assign q = chain[CW-1 -: W];
endmodule

// File: rtl/sps_front.sv
// Edge detection, address capture and mode decode.
// Assumes synchronized inputs; the address is shifted only while chip-enable is low.
module sps_front
    import sps_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ce_s,
    input  logic  sclk_s,
    input  logic  din_s,
    output logic  ce_rise,
    output logic  ce_fall,
    output logic  sclk_rise,
    output logic  sclk_fall,
    output mode_e mode
);
    logic              ce_d;
    logic              sclk_d;
    logic [ADDR_W-1:0] addr_sh;

    // Remember last levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_d   <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            ce_d   <= ce_s;
            sclk_d <= sclk_s;
        end
    end

    assign ce_rise   = ce_s & ~ce_d;
    assign ce_fall   = ~ce_s & ce_d;
    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    // Collect address bits LSB first while chip-enable is low
    always_ff @(posedge clk) begin
        if (!rst_n)                  addr_sh <= '0;
        else if (sclk_rise && !ce_s) addr_sh <= {din_s, addr_sh[ADDR_W-1:1]};
    end

    // Commit the mode on chip-enable rise, drop it on release
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= MD_IDLE;
        else if (ce_rise) mode <= decode_addr({addr_sh[3:0], addr_sh[7:4]});
        else if (ce_fall) mode <= MD_IDLE;
    end
endmodule

// File: rtl/sps_wr.sv
// Data word assembler and write banks.
// A bank takes the word at chip-enable release only after exactly DATA_W bits.
module sps_wr #(
    parameter int unsigned DATA_W  = 24,
    parameter int unsigned N_BANKS = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_BANKS-1:0]               wr_sel,
    input  logic                             sclk_rise,
    input  logic                             din_s,
    input  logic                             ce_fall,
    output logic [N_BANKS-1:0]               upd,
    output logic [N_BANKS-1:0][DATA_W-1:0]   banks_q
);
    localparam int unsigned CW = $clog2(DATA_W + 2);
    localparam logic [CW-1:0] FULL = CW'(DATA_W);
    localparam logic [CW-1:0] OVER = CW'(DATA_W + 1);

    logic [DATA_W-1:0] sh;
    logic [CW-1:0]     cnt;
    logic              wr_act;
    logic              full;

    assign wr_act = |wr_sel;
    assign full   = (cnt == FULL);

    // Shift data bits in, first bit ending at bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)                  sh <= '0;
        else if (sclk_rise && wr_act) sh <= {din_s, sh[DATA_W-1:1]};
    end

    // Count data bits, saturating one past the word length
    always_ff @(posedge clk) begin
        if (!rst_n || ce_fall)                         cnt <= '0;
        else if (sclk_rise && wr_act && cnt != OVER)   cnt <= cnt + 1'b1;
    end

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        logic [DATA_W-1:0] bank_r;

        assign upd[g] = ce_fall && wr_sel[g] && full;

        // Latch the assembled word into this bank
        always_ff @(posedge clk) begin
            if (!rst_n)      bank_r <= '0;
            else if (upd[g]) bank_r <= sh;
        end

        assign banks_q[g] = bank_r;
    end
endmodule

// File: rtl/sps_rd.sv
// Read shifter: loads a snapshot at chip-enable rise, shifts MSB first on
// shift-clock falls while read mode is active, zero-filling behind.
module sps_rd #(
    parameter int unsigned RD_W = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_rise,
    input  logic            sclk_fall,
    input  logic            rd_act,
    input  logic [RD_W-1:0] snap,
    output logic            dout
);
    logic [RD_W-1:0] sh;

    // Load the snapshot, then shift it out one bit per falling edge
    always_ff @(posedge clk) begin
        if (!rst_n)                  sh <= '0;
        else if (ce_rise)            sh <= snap;
        else if (sclk_fall && rd_act) sh <= {sh[RD_W-2:0], 1'b0};
    end

    assign dout = sh[RD_W-1];
endmodule

// File: rtl/sps_serial_slave.sv
// Address-prefixed serial control slave (top).
// Assumes the serial lines hold each level for several system clocks.
// The counter input is quasi-static; it is captured at the start of a read.
module sps_serial_slave
    import sps_pkg::*;
#(
    parameter int unsigned DATA_W  = 24,
    parameter int unsigned CNT_W   = 20,
    parameter int unsigned PORT_N  = 4,
    parameter int unsigned STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              ser_clk,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_dout_oe,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              bio_in,
    output logic [PORT_N-1:0] port_low,
    output logic              bio_low,
    output logic [DATA_W-1:0] bank1_q,
    output logic [DATA_W-1:0] bank2_q,
    output logic [DATA_W-1:0] bank3_q
);
    localparam int unsigned N_BANKS = 3;
    localparam int unsigned RD_W    = CNT_W + 1;
    localparam int unsigned DIR_BIT = PORT_N;
    localparam int unsigned VAL_BIT = PORT_N + 1;

    logic [3:0]                       sync_q;
    logic                             ce_s, sclk_s, din_s, bio_s;
    logic                             ce_rise, ce_fall, sclk_rise, sclk_fall;
    mode_e                            mode;
    logic [N_BANKS-1:0]               wr_sel;
    logic [N_BANKS-1:0]               upd;
    logic [N_BANKS-1:0][DATA_W-1:0]   banks;
    logic                             rd_act;

    sps_sync #(.W(4), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bio_in, ser_din, ser_clk, ser_en}),
        .q     (sync_q)
    );

    assign {bio_s, din_s, sclk_s, ce_s} = sync_q;

    sps_front u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_s      (ce_s),
        .sclk_s    (sclk_s),
        .din_s     (din_s),
        .ce_rise   (ce_rise),
        .ce_fall   (ce_fall),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mode      (mode)
    );

    assign wr_sel = {mode == MD_WR3, mode == MD_WR2, mode == MD_WR1};

    sps_wr #(.DATA_W(DATA_W), .N_BANKS(N_BANKS)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (wr_sel),
        .sclk_rise (sclk_rise),
        .din_s     (din_s),
        .ce_fall   (ce_fall),
        .upd       (upd),
        .banks_q   (banks)
    );

    assign rd_act = (mode == MD_RD) && ce_s;

    sps_rd #(.RD_W(RD_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_rise   (ce_rise),
        .sclk_fall (sclk_fall),
        .rd_act    (rd_act),
        .snap      ({bio_s, cnt_in}),
        .dout      (ser_dout)
    );

    assign ser_dout_oe = rd_act;
    assign bank1_q     = banks[0];
    assign bank2_q     = banks[1];
    assign bank3_q     = banks[2];
    assign port_low    = banks[0][PORT_N-1:0];
    assign bio_low     = banks[0][DIR_BIT] & banks[0][VAL_BIT];
endmodule

// File: rtl/sps_serial_slave_chk.sv
// Assertion checker for the serial control slave, bound to the top.
module sps_serial_slave_chk
    import sps_pkg::*;
#(
    parameter int unsigned DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_s,
    input logic              ce_fall,
    input logic              sclk_fall,
    input mode_e             mode,
    input logic [2:0]        upd,
    input logic              dout,
    input logic              oe,
    input logic [DATA_W-1:0] b1,
    input logic [DATA_W-1:0] b2,
    input logic [DATA_W-1:0] b3
);
    AST_BANK_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({b1, b2, b3}) |-> $past(ce_fall)); // R4
    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd)); // R2
    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (mode == MD_RD)); // R6
    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && $past(oe) && !$past(sclk_fall)) |-> $stable(dout)); // R5
    AST_IDLE_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_s && !$past(ce_s)) |-> (mode == MD_IDLE)); // R1
endmodule

bind sps_serial_slave sps_serial_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_s      (ce_s),
    .ce_fall   (ce_fall),
    .sclk_fall (sclk_fall),
    .mode      (mode),
    .upd       (upd),
    .dout      (ser_dout),
    .oe        (ser_dout_oe),
    .b1        (bank1_q),
    .b2        (bank2_q),
    .b3        (bank3_q)
);

// File: tb/sim_sps_serial_slave.sv
module sim_sps_serial_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
    logic        ser_dout, ser_dout_oe;
    logic [19:0] cnt_in = '0;
    logic        bio_in = 1'b0;
    logic [3:0]  port_low;
    logic        bio_low;
    logic [23:0] bank1_q, bank2_q, bank3_q;

    int n_run = 0;
    int n_fail = 0;
    logic [23:0] e1 = '0, e2 = '0, e3 = '0;

    always #2 clk = ~clk;

    sps_serial_slave u0 (.*);

    // addr[37:30], nbits[29:24], data[23:0]
    localparam logic [37:0] VEC [8] = '{
        {8'h82, 6'd24, 24'h000035},
        {8'h92, 6'd24, 24'hABCDEF},
        {8'hB2, 6'd24, 24'h123456},
        {8'h82, 6'd23, 24'hFFFFFF},
        {8'h92, 6'd25, 24'h000000},
        {8'hC2, 6'd24, 24'h777777},
        {8'hB2, 6'd24, 24'h800001},
        {8'h82, 6'd24, 24'h000010}
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        ser_din = b; wt(8);
        ser_clk = 1'b1; wt(8);
        ser_clk = 1'b0; wt(8);
    endtask

    task automatic start_frame(input logic [7:0] a);
        ser_en = 1'b0; wt(8);
        for (int i = 0; i < 4; i++) send_bit(a[4+i]);
        for (int i = 0; i < 4; i++) send_bit(a[i]);
        ser_en = 1'b1; wt(8);
    endtask

    task automatic end_frame();
        wt(8); ser_en = 1'b0; wt(10);
    endtask

    task automatic write_frame(input logic [7:0] a, input int n, input logic [23:0] d);
        start_frame(a);
        chk(ser_dout_oe == 1'b0, "R6 oe in write frame", 32'(ser_dout_oe), 0);
        for (int i = 0; i < n; i++) send_bit(i < 24 ? d[i] : 1'b1);
        end_frame();
    endtask

    task automatic check_banks(input string tag);
        chk(bank1_q == e1, tag, 32'(bank1_q), 32'(e1));
        chk(bank2_q == e2, tag, 32'(bank2_q), 32'(e2));
        chk(bank3_q == e3, tag, 32'(bank3_q), 32'(e3));
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wt(5);
        rst_n = 1'b1; wt(4);
        // R9 reset state
        check_banks("R9 reset banks");
        chk(port_low == 4'h0, "R9 ports float", 32'(port_low), 0);
        chk(bio_low == 1'b0, "R9 bidir input", 32'(bio_low), 0);
        chk(ser_dout_oe == 1'b0, "R9 oe low", 32'(ser_dout_oe), 0);

        // Vector table: R1 R2 R3 R4 R10
        foreach (VEC[k]) begin
            logic [7:0]  a;
            int          n;
            logic [23:0] d;
            a = VEC[k][37:30];
            n = int'(VEC[k][29:24]);
            d = VEC[k][23:0];
            write_frame(a, n, d);
            if (n == 24) begin
                if (a == 8'h82) e1 = d;
                if (a == 8'h92) e2 = d;
                if (a == 8'hB2) e3 = d;
            end
            check_banks($sformatf("R2 R3 R4 R10 vector %0d", k));
        end

        // R7 R8: ports from bank 1, bidir with direction input
        write_frame(8'h82, 24, 24'h00002A);
        chk(port_low == 4'b1010, "R7 port bits", 32'(port_low), 32'hA);
        chk(bio_low == 1'b0, "R8 dir input ignores value", 32'(bio_low), 0);
        write_frame(8'h82, 24, 24'h00003F);
        chk(port_low == 4'hF, "R7 all ports low", 32'(port_low), 32'hF);
        chk(bio_low == 1'b1, "R8 dir output drives low", 32'(bio_low), 1);
        e1 = 24'h00003F;

        // R5 read mode
        cnt_in = 20'hA5C3F;
        bio_in = 1'b1;
        start_frame(8'hA2);
        chk(ser_dout_oe == 1'b1, "R5 oe in read", 32'(ser_dout_oe), 1);
        for (int i = 0; i < 24; i++) begin
            logic e;
            e = (i == 0) ? 1'b1 : (i <= 20) ? cnt_in[20-i] : 1'b0;
            chk(ser_dout == e, $sformatf("R5 read bit %0d", i), 32'(ser_dout), 32'(e));
            ser_clk = 1'b1; wt(8);
            ser_clk = 1'b0; wt(8);
        end
        end_frame();
        chk(ser_dout_oe == 1'b0, "R6 oe after read", 32'(ser_dout_oe), 0);
        check_banks("R5 read leaves banks");

        // R10: unknown address keeps output disabled
        start_frame(8'h55);
        chk(ser_dout_oe == 1'b0, "R10 unknown addr oe", 32'(ser_dout_oe), 0);
        end_frame();

        // R9: reset after activity
        rst_n = 1'b0; wt(3);
        rst_n = 1'b1; wt(3);
        e1 = '0; e2 = '0; e3 = '0;
        check_banks("R9 banks after reset");
        chk(bio_low == 1'b0, "R9 bidir back to input", 32'(bio_low), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule